// File: doc/BRIEF.md
# Burst Wrap Read Address Generator

This block produces the byte address sequence for quad-width reads from a serial flash. The read engine loads a start address and then pulses an advance strobe once per byte. Each strobe moves the address either up by one, linearly, or around an aligned section of 8, 16, 32 or 64 bytes inside a 256-byte page. The address stays inside that section until the read engine loads a new start address. The read engine drops the read when chip select rises.

The wrap setting is loaded by its own serial command. The block watches the serial lines through a per-edge strobe, one strobe for each rising serial clock edge, and decodes frames itself. It keeps three setting bits: an active-low wrap enable and a two-bit section-length code. The setting applies to every read that starts later. A read that is already running keeps the mode it latched when it was loaded.

Top module: `burst_wrap_addr_gen`

## Requirements
- R1: After synchronous reset, `rd_addr` is 0, wrap is disabled and the stored length code is 00.
- R2: A setting frame runs while `cs_n` is low, one serial bit or nibble per `sclk_rise`. The first 8 strobes carry opcode 0x77 on `io_in[0]`, most significant bit first. Strobes 9 to 14 are dummy nibbles. Strobe 15 carries the high wrap nibble (`io_in[3]`=W7, `io_in[2]`=W6, `io_in[1]`=W5, `io_in[0]`=W4). Strobe 16 carries the low nibble W3-0. The new setting is in force from the cycle of strobe 16.
- R3: Only W6, W5 and W4 are stored. W7 and W3-0 have no effect on the address sequence.
- R4: W4=0 enables wrap and W4=1 disables it. With wrap on, the code {W6,W5} selects the section length: 00 for 8 bytes, 01 for 16, 10 for 32 and 11 for 64.
- R5: With wrap on, an advance increments only the low log2(length) address bits, modulo the length. All upper bits keep their start values.
- R6: With wrap off, an advance adds one to the whole address, across page boundaries, modulo 2^ADDR_W.
- R7: A frame cut short by `cs_n` rising before strobe 16 leaves the setting unchanged. So does a frame with any opcode other than 0x77.
- R8: Strobes seen while `cs_n` is high are ignored. Strobes after the sixteenth in one frame are also ignored.
- R9: `rd_load` puts `rd_start` on `rd_addr` one cycle later. If `rd_load` and `rd_adv` are high in the same cycle, the load wins.
- R10: A read latches the setting that is in force when it is loaded. If strobe 16 of a setting frame falls in the same cycle as `rd_load`, the new setting is used. A setting committed during a read takes effect only at the next load.
- R11: With neither `rd_load` nor `rd_adv` high, `rd_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk_rise | input | 1 | One-cycle pulse per rising serial clock edge |
| io_in | input | 4 | Serial data lines sampled on `sclk_rise` |
| rd_load | input | 1 | Load `rd_start` as the next read start |
| rd_start | input | ADDR_W | Read start address |
| rd_adv | input | 1 | Advance one byte |
| rd_addr | output | ADDR_W | Current read address |

## Verification
Two events can fall in the same cycle: the commit on the last strobe of a setting frame and a read load. The bench provokes this by raising `rd_load` on strobe 16 of a frame that switches on 8-byte wrap. The next advance must then wrap inside the new 8-byte section. A second collision puts a commit in the middle of a running read: the following advances must still follow the mode latched at load. Load and advance are also asserted together, and the loaded start address must win.

// File: rtl/burst_wrap_pkg.sv
package burst_wrap_pkg;

    // Section length selector, value = {W6,W5}
    typedef enum logic [1:0] {
        SEC_8  = 2'b00,
        SEC_16 = 2'b01,
        SEC_32 = 2'b10,
        SEC_64 = 2'b11
    } sec_len_e;

    // Stored setting; wrap_off is the active-low enable (W4)
    typedef struct packed {
        logic     wrap_off;
        sec_len_e len;
    } wrap_cfg_t;

    localparam wrap_cfg_t CFG_AT_RESET = '{wrap_off: 1'b1, len: SEC_8};

    localparam int SEC_BITS_MAX = 6;

    // Mask of the low address bits that move inside a section
    function automatic logic [SEC_BITS_MAX-1:0] sec_mask(input sec_len_e len);
        logic [SEC_BITS_MAX-1:0] m;
        unique case (len)
            SEC_8:   m = 6'b000111;
            SEC_16:  m = 6'b001111;
            SEC_32:  m = 6'b011111;
            default: m = 6'b111111;
        endcase
        return m;
    endfunction

    // Unpack stored bits from the high wrap nibble (W6,W5,W4)
    function automatic wrap_cfg_t cfg_from_bits(input logic [2:0] w);
        wrap_cfg_t c;
        c.wrap_off = w[0];
        c.len      = sec_len_e'(w[2:1]);
        return c;
    endfunction

endpackage

// File: rtl/wrap_cmd_decoder.sv
module wrap_cmd_decoder
    import burst_wrap_pkg::*;
#(
    parameter logic [7:0] OPCODE    = 8'h77,
    parameter int         OPC_BITS  = 8,
    parameter int         DUMMY_NIB = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sclk_rise,
    input  logic [3:0] io_in,
    output logic      commit,
    output wrap_cfg_t cfg_new
);
    localparam int HI_IDX = OPC_BITS + DUMMY_NIB;
    localparam int TOTAL  = HI_IDX + 2;
    localparam int CNT_W  = $clog2(TOTAL + 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [OPC_BITS-1:0] opc_q;
    logic [OPC_BITS-1:0] opc_next;
    logic                hit_q;
    logic [2:0]          wbits_q;
    logic                stb_ok;

    assign stb_ok   = sclk_rise && !cs_n;
    assign opc_next = {opc_q[OPC_BITS-2:0], io_in[0]};

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            cnt_q   <= '0;
            opc_q   <= '0;
            hit_q   <= 1'b0;
            wbits_q <= '0;
        end else if (stb_ok && (cnt_q < CNT_W'(TOTAL))) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < CNT_W'(OPC_BITS))
                opc_q <= opc_next;
            if (cnt_q == CNT_W'(OPC_BITS - 1))
                hit_q <= (opc_next == OPCODE);
            if (cnt_q == CNT_W'(HI_IDX))
                wbits_q <= io_in[2:0];
        end
    end

    assign commit  = stb_ok && hit_q && (cnt_q == CNT_W'(TOTAL - 1));
    assign cfg_new = cfg_from_bits(wbits_q);

    // R8: frame position never runs past the last strobe
    a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(TOTAL));
    // R7: a raised chip select restarts the frame
    a_r7_cs_restarts: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cnt_q == '0) && !hit_q);
    // R2: a commit is only possible once the opcode has been matched
    a_r2_commit_after_opcode: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(hit_q || (cnt_q == CNT_W'(OPC_BITS))));

endmodule

// File: rtl/wrap_cfg_reg.sv
module wrap_cfg_reg
    import burst_wrap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  wrap_cfg_t cfg_new,
    output wrap_cfg_t cfg_eff
);
    wrap_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_AT_RESET;
        else if (commit)
            cfg_q <= cfg_new;
    end

    // Forward a commit so a load in the same cycle sees it
    assign cfg_eff = commit ? cfg_new : cfg_q;

    // R7: the stored setting only changes on a commit
    a_r7_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cfg_q));
    // R1: held setting after reset is the disabled default until a commit
    a_r1_reset_default: assert property (@(posedge clk)
        rst |=> cfg_q == CFG_AT_RESET);

endmodule

// File: rtl/burst_addr_stepper.sv
module burst_addr_stepper
    import burst_wrap_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] rd_start,
    input  logic              rd_adv,
    input  wrap_cfg_t         cfg_eff,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - SEC_BITS_MAX;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_step;
    logic [ADDR_W-1:0] mask_full;
    logic [ADDR_W-1:0] addr_inc;
    wrap_cfg_t         mode_q;

    assign mask_full = {{PAD_W{1'b0}}, sec_mask(mode_q.len)};
    assign addr_inc  = addr_q + 1'b1;

    always_comb begin
        if (mode_q.wrap_off)
            addr_step = addr_inc;
        else
            addr_step = (addr_q & ~mask_full) | (addr_inc & mask_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mode_q <= CFG_AT_RESET;
        end else if (rd_load) begin
            addr_q <= rd_start;
            mode_q <= cfg_eff;
        end else if (rd_adv) begin
            addr_q <= addr_step;
        end
    end

    assign addr = addr_q;

    // R9: a load wins and appears one cycle later
    a_r9_load: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> addr_q == $past(rd_start));
    // R11: no request, no movement
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_load && !rd_adv |=> $stable(addr_q));
    // R5: wrapped advance keeps the bits above the section
    a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        rd_adv && !rd_load && !mode_q.wrap_off |=>
            (addr_q & ~mask_full) == ($past(addr_q) & ~mask_full));
    // R6: linear advance adds one
    a_r6_linear: assert property (@(posedge clk) disable iff (rst)
        rd_adv && !rd_load && mode_q.wrap_off |=> addr_q == $past(addr_q) + 1'b1);
    // R10: the latched mode holds while no load occurs
    a_r10_mode_held: assert property (@(posedge clk) disable iff (rst)
        !rd_load |=> $stable(mode_q));

endmodule

// File: rtl/burst_wrap_addr_gen.sv
module burst_wrap_addr_gen
    import burst_wrap_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter logic [7:0] OPCODE    = 8'h77,
    parameter int         DUMMY_NIB = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic [3:0]        io_in,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] rd_start,
    input  logic              rd_adv,
    output logic [ADDR_W-1:0] rd_addr
);
    logic      commit;
    wrap_cfg_t cfg_new;
    wrap_cfg_t cfg_eff;

    wrap_cmd_decoder #(
        .OPCODE    (OPCODE),
        .OPC_BITS  (8),
        .DUMMY_NIB (DUMMY_NIB)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .io_in     (io_in),
        .commit    (commit),
        .cfg_new   (cfg_new)
    );

    wrap_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .cfg_new (cfg_new),
        .cfg_eff (cfg_eff)
    );

    burst_addr_stepper #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .clk      (clk),
        .rst      (rst),
        .rd_load  (rd_load),
        .rd_start (rd_start),
        .rd_adv   (rd_adv),
        .cfg_eff  (cfg_eff),
        .addr     (rd_addr)
    );

    // R3: a commit never loads a setting outside the three stored bits
    a_r3_commit_clean: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$isunknown(cfg_new));

endmodule

// File: tb/sim_burst_wrap_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_wrap_addr_gen;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk_rise = 1'b0;
    logic [3:0]    io_in = '0;
    logic          rd_load = 1'b0;
    logic [AW-1:0] rd_start = '0;
    logic          rd_adv = 1'b0;
    logic [AW-1:0] rd_addr;

    always #2 clk = ~clk;

    burst_wrap_addr_gen #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_rise(sclk_rise), .io_in(io_in),
        .rd_load(rd_load), .rd_start(rd_start), .rd_adv(rd_adv), .rd_addr(rd_addr)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // scoreboard
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];
    bit            mon_arm = 0;

    // bench model of the requirements
    bit        m_off  = 1;   // stored W4
    bit [1:0]  m_code = 0;   // stored {W6,W5}
    bit        r_off  = 1;   // mode latched by current read
    bit [1:0]  r_code = 0;
    logic [AW-1:0] m_addr = '0;

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                                input bit off, input bit [1:0] code);
        int unsigned len;
        logic [AW-1:0] base;
        if (off) return a + 1;
        len  = 8 << code;
        base = a - (a % len);
        return base + ((a - base + 1) % len);
    endfunction

    always @(negedge clk) begin
        if (mon_arm) begin
            logic [AW-1:0] e;
            string t;
            mon_arm = 0;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (rd_addr !== e) begin
                fails++;
                $display("FAIL %s: rd_addr=%h expected %h", t, rd_addr, e);
            end
        end
    end

    task automatic step(input bit stb, input logic [3:0] io, input bit csn,
                        input bit ld, input logic [AW-1:0] sa, input bit adv,
                        input string tag);
        @(negedge clk);
        sclk_rise = stb; io_in = io; cs_n = csn;
        rd_load = ld; rd_start = sa; rd_adv = adv;
        if (ld) begin
            r_off = m_off; r_code = m_code; m_addr = sa;
        end else if (adv) begin
            m_addr = next_addr(m_addr, r_off, r_code);
        end
        @(posedge clk);
        #1;
        exp_q.push_back(m_addr);
        tag_q.push_back(tag);
        mon_arm = 1;
    endtask

    task automatic idle(input string tag);
        step(0, 4'h0, 1, 0, '0, 0, tag);
    endtask

    // setting frame; optional load on the last strobe
    task automatic send_cfg(input logic [7:0] opc, input logic [3:0] whi,
                            input logic [3:0] wlo, input int n,
                            input bit ld_last, input logic [AW-1:0] sa,
                            input string tag);
        for (int i = 0; i < n; i++) begin
            logic [3:0] io;
            bit last;
            if (i < 8)        io = {3'b000, opc[7-i]};
            else if (i == 14) io = whi;
            else if (i == 15) io = wlo;
            else              io = 4'hA;
            last = (i == 15);
            if (last && opc == 8'h77) begin
                m_off = whi[0]; m_code = whi[2:1];
            end
            step(1, io, 0, last && ld_last, sa, 0, tag);
        end
        idle(tag);
    endtask

    task automatic burst(input logic [AW-1:0] sa, input int n, input string tag);
        step(0, 4'h0, 1, 1, sa, 0, tag);
        for (int i = 0; i < n; i++) step(0, 4'h0, 1, 0, '0, 1, tag);
        idle(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tests++;
        if (rd_addr !== '0) begin
            fails++;
            $display("FAIL R1: rd_addr=%h expected %h", rd_addr, 24'h0);
        end
        // R1/R6: default is linear, crossing a page boundary
        burst(24'h0000FE, 4, "R1_R6");
        // R8: strobes with cs_n high do nothing
        for (int i = 0; i < 20; i++) step(1, 4'h0, 1, 0, '0, 0, "R8");
        burst(24'h0001FF, 2, "R8");
        // R2/R3/R4/R5: 8-byte wrap, W7 and W3-0 set to junk
        send_cfg(8'h77, 4'b1000, 4'hF, 16, 0, '0, "R2");
        burst(24'h123405, 5, "R3_R5");
        // R4: 16, 32, 64-byte sections
        send_cfg(8'h77, 4'b0010, 4'h0, 16, 0, '0, "R4");
        burst(24'hABCD1E, 3, "R4_16");
        send_cfg(8'h77, 4'b0100, 4'h5, 16, 0, '0, "R4");
        burst(24'h00003E, 3, "R4_32");
        send_cfg(8'h77, 4'b0110, 4'h0, 16, 0, '0, "R4");
        burst(24'h0000FF, 2, "R4_64");
        // R7: truncated frame and wrong opcode leave the 64-byte setting
        send_cfg(8'h77, 4'b0001, 4'h0, 15, 0, '0, "R7");
        burst(24'h00007F, 1, "R7_trunc");
        send_cfg(8'h78, 4'b0001, 4'h0, 16, 0, '0, "R7");
        burst(24'h00007F, 1, "R7_opc");
        // R8: extra strobes after 16 ignored (frame continues with junk)
        for (int i = 0; i < 16; i++)
            step(1, (i < 8) ? {3'b000, 8'h77 >> (7-i) & 1'b1} :
                    (i == 14) ? 4'b0000 : 4'h0, 0, 0, '0, 0, "R8");
        m_off = 0; m_code = 0;
        for (int i = 0; i < 4; i++) step(1, 4'b0111, 0, 0, '0, 0, "R8");
        idle("R8");
        burst(24'h00000E, 2, "R8_extra");
        // R6: disable wrap, linear again, and wrap of the full address
        send_cfg(8'h77, 4'b0001, 4'h0, 16, 0, '0, "R6");
        burst(24'hFFFFFF, 2, "R6_top");
        // R10: commit in the same cycle as load uses the new setting
        send_cfg(8'h77, 4'b0000, 4'h0, 16, 1, 24'h00000F, "R10_same");
        step(0, 4'h0, 1, 0, '0, 1, "R10_same");
        // R10: commit mid-read does not touch the running read
        step(0, 4'h0, 1, 1, 24'h000005, 0, "R10_mid");
        step(0, 4'h0, 1, 0, '0, 1, "R10_mid");
        send_cfg(8'h77, 4'b0001, 4'h0, 16, 0, '0, "R10_mid");
        step(0, 4'h0, 1, 0, '0, 1, "R10_mid");
        step(0, 4'h0, 1, 0, '0, 1, "R10_mid");
        burst(24'h000007, 1, "R10_next");
        // R9: load wins over advance; R11: hold
        step(0, 4'h0, 1, 1, 24'h000055, 1, "R9");
        idle("R11");
        idle("R11");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: rd_addr=%h expected %s", rd_addr, "completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule